// File: doc/BRIEF.md
# Pendulum Position PD Loop

This block closes a fixed-rate position loop around a DC motor that swings a pendulum. A free-running divider produces one control strobe per loop period (10 ms at the default clock). In each strobed cycle the block picks the target angle, converts the signed encoder count into an angle, forms the error, and applies a proportional-plus-derivative law in signed fixed point. The result is limited to a safe magnitude and split into a duty magnitude and two motor-direction lines.

The target angle comes from one of two sources chosen by a mode input: a constant parameter, or a square wave that alternates between a negative and a positive amplitude every `TOGGLE_TICKS` loop periods (one second at the default). Angles are Q12 radians, so the default amplitude 2458 is about 0.6 rad. Quadrature decoding, PWM waveform generation and gravity compensation sit outside the block.

Top module: `pd_loop`

## Requirements
- R1: A loop iteration fires in every `TICK_CYCLES`-th clock cycle after reset release. All outputs update only on the clock edge that closes that cycle and hold their values through the other cycles.
- R2: With `squareMode`=1, the setpoint is -`AMP` for the first `TOGGLE_TICKS` iterations after reset. It is +`AMP` for the next `TOGGLE_TICKS` iterations, and then keeps alternating.
- R3: With `squareMode`=0, the setpoint is `FIXED_POS`. The square-wave period count keeps advancing while this mode is selected.
- R4: The error is the setpoint minus `encCount`×`POS_SCALE`, in Q12 radians.
- R5: The raw output is (`KP`×error + `KD`×(error − previous error)) shifted right arithmetically by `OUT_SHIFT`, which rounds toward minus infinity. The error of each iteration is stored as the previous error.
- R6: On the first iteration after reset, the derivative term is zero.
- R7: The raw output is clamped to the range [−`DUTY_LIMIT`, +`DUTY_LIMIT`].
- R8: `dutyMag` is the magnitude of the clamped output. A positive output gives `drvFwd`=1 and `drvRev`=0. A negative output gives `drvFwd`=0 and `drvRev`=1. A zero output gives 0 on both lines.
- R9: While `rst` is high, at the next clock edge `dutyMag`, `drvFwd`, `drvRev` and `setpointOut` go to 0. Reset also clears the previous error, the tick and period counts, and the square-wave phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| encCount | input | ENC_W | Signed encoder position in counts |
| squareMode | input | 1 | 1 selects the square-wave setpoint, 0 selects the fixed setpoint |
| dutyMag | output | DUTY_W | Duty magnitude for the motor driver |
| drvFwd | output | 1 | Forward direction line |
| drvRev | output | 1 | Reverse direction line |
| setpointOut | output | SP_W | Setpoint used by the last iteration, signed Q12 rad |

## Verification
Two functions can land in the same iteration. One is the square-wave flip of the setpoint. The other is the derivative step that this flip causes, which, together with the clamp, can drive the output from one limit to the other in a single tick. The bench shortens the period count so that flips fall inside its vector table, including on iterations where the encoder input also jumps. Every tick is judged against a reference model computed from the requirements, which also checks that nothing moves in the cycle before the tick.

// File: rtl/pd_loop_pkg.sv
`timescale 1ns/1ps
package pd_loop_pkg;
  // strobes and levels passed from sequencing control to the arithmetic path
  typedef struct packed {
    logic tick;       // this cycle runs one loop iteration
    logic firstTick;  // no iteration has run since reset
    logic phaseHigh;  // square wave currently in its positive half
  } ctlStrobes_t;
endpackage

// File: rtl/pd_loop_ctrl.sv
`timescale 1ns/1ps
module pd_loop_ctrl
  import pd_loop_pkg::*;
#(
  parameter int TICK_CYCLES  = 1000000,
  parameter int TOGGLE_TICKS = 100
) (
  input  logic        clk,
  input  logic        rst,
  output ctlStrobes_t strobes
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int PW = (TOGGLE_TICKS > 1) ? $clog2(TOGGLE_TICKS) : 1;

  logic [TW-1:0] tickCnt;
  logic [PW-1:0] phaseCnt;
  logic          phaseHigh;
  logic          primed;
  logic          tickNow;

  assign tickNow = (tickCnt == TW'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (tickNow) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // period count runs in both setpoint modes
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt  <= '0;
      phaseHigh <= 1'b0;
      primed    <= 1'b0;
    end else if (tickNow) begin
      primed <= 1'b1;
      if (phaseCnt == PW'(TOGGLE_TICKS - 1)) begin
        phaseCnt  <= '0;
        phaseHigh <= ~phaseHigh;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.tick      = tickNow;
    strobes.firstTick = ~primed;
    strobes.phaseHigh = phaseHigh;
  end
endmodule

// File: rtl/pd_loop_dp.sv
`timescale 1ns/1ps
module pd_loop_dp
  import pd_loop_pkg::*;
#(
  parameter int ENC_W      = 16,
  parameter int SP_W       = 16,
  parameter int DUTY_W     = 10,
  parameter int POS_SCALE  = 13,
  parameter int AMP        = 2458,
  parameter int FIXED_POS  = 0,
  parameter int KP         = 512,
  parameter int KD         = 1024,
  parameter int OUT_SHIFT  = 12,
  parameter int DUTY_LIMIT = 900
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctlStrobes_t             strobes,
  input  logic signed [ENC_W-1:0] encCount,
  input  logic                    squareMode,
  output logic [DUTY_W-1:0]       dutyMag,
  output logic                    drvFwd,
  output logic                    drvRev,
  output logic signed [SP_W-1:0]  setpointOut
);
  localparam int ERR_W = ENC_W + SP_W;
  localparam int ACC_W = ERR_W + 24;

  logic signed [SP_W-1:0]  spNext;
  logic signed [ERR_W-1:0] prevErr;
  logic signed [ACC_W-1:0] errA, diffA, rawA, clampA, magA;
  logic [DUTY_W-1:0]       dutyNext;

  always_comb begin
    if (squareMode) begin
      spNext = strobes.phaseHigh ? SP_W'(AMP) : SP_W'(-AMP);
    end else begin
      spNext = SP_W'(FIXED_POS);
    end

    errA  = ACC_W'(spNext) - ACC_W'(encCount) * ACC_W'(POS_SCALE);
    diffA = strobes.firstTick ? '0 : (errA - ACC_W'(prevErr));
    rawA  = (ACC_W'(KP) * errA + ACC_W'(KD) * diffA) >>> OUT_SHIFT;

    if (rawA > ACC_W'(DUTY_LIMIT)) begin
      clampA = ACC_W'(DUTY_LIMIT);
    end else if (rawA < ACC_W'(-DUTY_LIMIT)) begin
      clampA = ACC_W'(-DUTY_LIMIT);
    end else begin
      clampA = rawA;
    end

    magA     = clampA[ACC_W-1] ? -clampA : clampA;
    dutyNext = DUTY_W'(magA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevErr     <= '0;
      dutyMag     <= '0;
      drvFwd      <= 1'b0;
      drvRev      <= 1'b0;
      setpointOut <= '0;
    end else if (strobes.tick) begin
      prevErr     <= ERR_W'(errA);
      dutyMag     <= dutyNext;
      drvFwd      <= (clampA > 0);
      drvRev      <= clampA[ACC_W-1];
      setpointOut <= spNext;
    end
  end
endmodule

// File: rtl/pd_loop.sv
`timescale 1ns/1ps
module pd_loop
  import pd_loop_pkg::*;
#(
  parameter int TICK_CYCLES  = 1000000,
  parameter int TOGGLE_TICKS = 100,
  parameter int ENC_W        = 16,
  parameter int SP_W         = 16,
  parameter int DUTY_W       = 10,
  parameter int POS_SCALE    = 13,
  parameter int AMP          = 2458,
  parameter int FIXED_POS    = 0,
  parameter int KP           = 512,
  parameter int KD           = 1024,
  parameter int OUT_SHIFT    = 12,
  parameter int DUTY_LIMIT   = 900
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ENC_W-1:0] encCount,
  input  logic                    squareMode,
  output logic [DUTY_W-1:0]       dutyMag,
  output logic                    drvFwd,
  output logic                    drvRev,
  output logic signed [SP_W-1:0]  setpointOut
);
  ctlStrobes_t strobes;

  pd_loop_ctrl #(
    .TICK_CYCLES (TICK_CYCLES),
    .TOGGLE_TICKS(TOGGLE_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  pd_loop_dp #(
    .ENC_W     (ENC_W),
    .SP_W      (SP_W),
    .DUTY_W    (DUTY_W),
    .POS_SCALE (POS_SCALE),
    .AMP       (AMP),
    .FIXED_POS (FIXED_POS),
    .KP        (KP),
    .KD        (KD),
    .OUT_SHIFT (OUT_SHIFT),
    .DUTY_LIMIT(DUTY_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .encCount   (encCount),
    .squareMode (squareMode),
    .dutyMag    (dutyMag),
    .drvFwd     (drvFwd),
    .drvRev     (drvRev),
    .setpointOut(setpointOut)
  );
endmodule

// File: rtl/pd_loop_chk.sv
`timescale 1ns/1ps
module pd_loop_chk #(
  parameter int DUTY_W     = 10,
  parameter int SP_W       = 16,
  parameter int AMP        = 2458,
  parameter int FIXED_POS  = 0,
  parameter int DUTY_LIMIT = 900
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tickStb,
  input logic                   squareMode,
  input logic [DUTY_W-1:0]      dutyMag,
  input logic                   drvFwd,
  input logic                   drvRev,
  input logic signed [SP_W-1:0] setpointOut
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(tickStb) |-> ($stable(dutyMag) && $stable(drvFwd) && $stable(drvRev) && $stable(setpointOut)));

  p_square_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(tickStb) && $past(squareMode)) |->
      (setpointOut == SP_W'(AMP) || setpointOut == SP_W'(-AMP)));

  p_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(tickStb) && !$past(squareMode)) |-> (setpointOut == SP_W'(FIXED_POS)));

  p_duty_limit_r7: assert property (@(posedge clk) disable iff (rst)
    dutyMag <= DUTY_W'(DUTY_LIMIT));

  p_dir_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(drvFwd && drvRev));

  p_duty_dir_r8: assert property (@(posedge clk) disable iff (rst)
    ((dutyMag == '0) == (!drvFwd && !drvRev)));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (dutyMag == '0 && !drvFwd && !drvRev && setpointOut == '0));
endmodule

bind pd_loop pd_loop_chk #(
  .DUTY_W    (DUTY_W),
  .SP_W      (SP_W),
  .AMP       (AMP),
  .FIXED_POS (FIXED_POS),
  .DUTY_LIMIT(DUTY_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tickStb    (strobes.tick),
  .squareMode (squareMode),
  .dutyMag    (dutyMag),
  .drvFwd     (drvFwd),
  .drvRev     (drvRev),
  .setpointOut(setpointOut)
);

// File: tb/tb_pd_loop.sv
`timescale 1ns/1ps
module tb_pd_loop;
  localparam int T       = 16;
  localparam int TOG     = 4;
  localparam int ENC_W   = 16;
  localparam int SP_W    = 16;
  localparam int DUTY_W  = 10;
  localparam int SCALE   = 13;
  localparam int AMP     = 2458;
  localparam int FIXPOS  = 1300;
  localparam int KP      = 512;
  localparam int KD      = 1024;
  localparam int SHIFT   = 12;
  localparam int LIMIT   = 600;
  localparam int NV      = 16;

  // encoder count and mode for each loop iteration
  localparam int VEC_ENC [NV] = '{0, 20, -30, 189, -189, 5000, -5000, 0,
                                   3, 100, 100, 90, 110, -7, 250, 0};
  localparam bit VEC_SQ  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1,
                                   1, 0, 0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [ENC_W-1:0] encCount = '0;
  logic squareMode = 1'b1;
  logic [DUTY_W-1:0] dutyMag;
  logic drvFwd, drvRev;
  logic signed [SP_W-1:0] setpointOut;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  longint mPrev;
  bit     mFirst;
  bit     mPhase;
  int     mCnt;
  int     expDuty, expSp;
  bit     expFwd, expRev;

  always #2.5 clk = ~clk;

  pd_loop #(
    .TICK_CYCLES(T), .TOGGLE_TICKS(TOG), .ENC_W(ENC_W), .SP_W(SP_W),
    .DUTY_W(DUTY_W), .POS_SCALE(SCALE), .AMP(AMP), .FIXED_POS(FIXPOS),
    .KP(KP), .KD(KD), .OUT_SHIFT(SHIFT), .DUTY_LIMIT(LIMIT)
  ) dut (
    .clk(clk), .rst(rst), .encCount(encCount), .squareMode(squareMode),
    .dutyMag(dutyMag), .drvFwd(drvFwd), .drvRev(drvRev), .setpointOut(setpointOut)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPrev = 0; mFirst = 1'b1; mPhase = 1'b0; mCnt = 0;
    expDuty = 0; expSp = 0; expFwd = 1'b0; expRev = 1'b0;
  endtask

  task automatic modelTick(input int enc, input bit sq);
    longint sp, err, dif, u;
    sp  = sq ? (mPhase ? AMP : -AMP) : FIXPOS;      // R2 R3
    err = sp - longint'(enc) * SCALE;               // R4
    dif = mFirst ? 0 : err - mPrev;                 // R6
    u   = (KP * err + KD * dif) >>> SHIFT;          // R5
    if (u > LIMIT) u = LIMIT;                       // R7
    if (u < -LIMIT) u = -LIMIT;
    expDuty = int'(u < 0 ? -u : u);                 // R8
    expFwd  = (u > 0);
    expRev  = (u < 0);
    expSp   = int'(sp);
    mPrev = err; mFirst = 1'b0;
    mCnt++;
    if (mCnt == TOG) begin mCnt = 0; mPhase = ~mPhase; end
  endtask

  // drives inputs at a negedge aligned to the start of a loop period
  task automatic doTick(input int enc, input bit sq, input string req);
    encCount = ENC_W'(enc);
    squareMode = sq;
    repeat (T - 1) @(posedge clk);
    @(negedge clk);
    // R1: nothing moves before the tick edge
    chk("R1", "hold duty", dutyMag, expDuty);
    chk("R1", "hold setpoint", setpointOut, expSp);
    @(posedge clk);
    @(negedge clk);
    modelTick(enc, sq);
    chk(req, "duty", dutyMag, expDuty);
    chk("R8", "fwd", drvFwd, expFwd);
    chk("R8", "rev", drvRev, expRev);
    chk(sq ? "R2" : "R3", "setpoint", setpointOut, expSp);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "reset duty", dutyMag, 0);
    chk("R9", "reset fwd", drvFwd, 0);
    chk("R9", "reset rev", drvRev, 0);
    chk("R9", "reset setpoint", setpointOut, 0);
    rst = 1'b0;

    // vector table: covers R4 R5 R7 and square flips every TOG ticks
    for (int i = 0; i < NV; i++) begin
      doTick(VEC_ENC[i], VEC_SQ[i], (VEC_ENC[i] > 1000 || VEC_ENC[i] < -1000) ? "R7" : "R5");
    end

    // R9: reset mid-run clears outputs
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "midrun duty", dutyMag, 0);
    chk("R9", "midrun setpoint", setpointOut, 0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();

    // R6: first iteration after reset has no derivative term
    doTick(50, 1'b1, "R6");
    chk("R6", "first-tick duty", dutyMag, ((KP * (-AMP - 50 * SCALE)) >>> SHIFT) < -LIMIT ? LIMIT
                                          : -((KP * (-AMP - 50 * SCALE)) >>> SHIFT));
    // R3: fixed mode, zero error twice gives zero output on both lines
    doTick(100, 1'b0, "R3");
    doTick(100, 1'b0, "R8");
    chk("R8", "zero out duty", dutyMag, 0);
    chk("R8", "zero out fwd", drvFwd, 0);
    chk("R8", "zero out rev", drvRev, 0);
    // R2: period count kept running in fixed mode; next square ticks follow the model
    doTick(0, 1'b1, "R2");
    doTick(0, 1'b1, "R2");
    // R7: swing from one clamp limit to the other
    doTick(-9000, 1'b1, "R7");
    doTick(9000, 1'b1, "R7");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule